// File: doc/BRIEF.md
# Serial Multiprocessor Address Filter

This block sits behind the receiver of a 9-bit multiprocessor serial link. It decides whether an address byte that the receiver has flagged is meant for this node. The block holds two registers. The node address register gives the value this node answers to. The care mask register picks which bits of that value take part in the compare. Both registers are written over a plain register bus. The filter is always active and has no enable bit. At the reset defaults every address byte matches, so a node that does not use addressing can ignore the block.

Each flagged byte is compared two ways. The first compare is against the node address, using only the bits that are set in the care mask. The second compare is against a broadcast pattern, which is the bitwise OR of the two registers. A bit that is zero in that pattern is a don't-care. The block reports the two results separately, together with their OR, as pulses one clock wide. The byte input is a valid-only stream. The filter takes one byte on every clock, so it never applies back-pressure and has no ready signal.

Top module: `saf_addr_filter`

## Requirements
- R1: After reset, both the node address register and the care mask register hold all zeros. At these values every flagged byte produces a hit on both the node-address compare and the broadcast compare.
- R2: A node-address hit is declared when the received byte equals the node address in every bit position where the care mask holds a 1. Bit positions where the mask holds a 0 are ignored.
- R3: A broadcast hit is declared when the received byte holds a 1 in every bit position where (node address OR care mask) holds a 1. All other positions are don't-cares.
- R4: `match_o` is the OR of `addr_hit_o` and `bcast_hit_o`.
- R5: The three outputs rise on the clock after a cycle in which `rx_valid_i` is high. They last exactly one clock unless the next cycle also carries a valid byte.
- R6: A byte presented while `rx_valid_i` is low produces no pulse on any output.
- R7: A register write with `reg_wr_i` high writes `reg_wdata_i` to the node address register when `reg_sel_i` = 0, and to the care mask register when `reg_sel_i` = 1. The new value takes effect from the next clock. A byte flagged in the same cycle as the write is compared against the old value.
- R8: Consecutive valid bytes on back-to-back clocks are each judged on their own, with one result per clock and no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = node address, 1 = care mask |
| reg_wdata_i | input | ADDR_W | Register write data |
| rx_valid_i | input | 1 | Address byte valid strobe; always accepted |
| rx_data_i | input | ADDR_W | Received address byte |
| match_o | output | 1 | Pulse: byte is for this node |
| addr_hit_o | output | 1 | Pulse: node-address compare hit |
| bcast_hit_o | output | 1 | Pulse: broadcast compare hit |

## Verification
The bench builds the filter with the default ADDR_W of 8. At that width a full sweep of all 256 byte values fits easily under each register setting. Every byte is scored against a model of both compares. The sweep covers the all-zero reset settings, partial masks in which the broadcast pattern differs from all ones, and a full mask in which the broadcast pattern is FFh. Directed cases cover a write that coincides with a flagged byte, bytes presented with the strobe low, and back-to-back bytes.

// File: rtl/saf_pkg.sv
package saf_pkg;
  // register select encoding on the write bus
  typedef enum logic {
    SEL_NODE = 1'b0,
    SEL_MASK = 1'b1
  } saf_sel_e;

  typedef struct packed {
    logic addr_hit;
    logic bcast_hit;
  } saf_hits_t;
endpackage

// File: rtl/saf_regs.sv
module saf_regs
  import saf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] node_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam logic [ADDR_W-1:0] RST_VAL = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      node_o <= RST_VAL;
      mask_o <= RST_VAL;
    end else if (wr_i) begin
      if (saf_sel_e'(sel_i) == SEL_NODE) node_o <= wdata_i;
      else                               mask_o <= wdata_i;
    end
  end

  // R7
  node_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i) |=> (node_o == $past(wdata_i)));
  // R7
  mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (mask_o == $past(wdata_i)));
  // R7
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(node_o) && $stable(mask_o)));
endmodule

// File: rtl/saf_cmp.sv
module saf_cmp
  import saf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] node_i,
  input  logic [ADDR_W-1:0] mask_i,
  output saf_hits_t         hits_o
);
  logic [ADDR_W-1:0] addr_ok;
  logic [ADDR_W-1:0] bcast_ok;

  // per-bit compare lanes
  for (genvar i = 0; i < ADDR_W; i++) begin : g_lane
    logic bpat;
    assign bpat        = node_i[i] | mask_i[i];
    assign addr_ok[i]  = !mask_i[i] || (byte_i[i] == node_i[i]);
    assign bcast_ok[i] = !bpat || byte_i[i];
  end

  assign hits_o.addr_hit  = &addr_ok;
  assign hits_o.bcast_hit = &bcast_ok;
endmodule

// File: rtl/saf_addr_filter.sv
module saf_addr_filter
  import saf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [ADDR_W-1:0] rx_data_i,
  output logic              match_o,
  output logic              addr_hit_o,
  output logic              bcast_hit_o
);
  logic [ADDR_W-1:0] node_q;
  logic [ADDR_W-1:0] mask_q;
  saf_hits_t         hits;

  saf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .node_o  (node_q),
    .mask_o  (mask_q)
  );

  saf_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_i (rx_data_i),
    .node_i (node_q),
    .mask_i (mask_q),
    .hits_o (hits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_hit_o  <= 1'b0;
      bcast_hit_o <= 1'b0;
      match_o     <= 1'b0;
    end else begin
      addr_hit_o  <= rx_valid_i && hits.addr_hit;
      bcast_hit_o <= rx_valid_i && hits.bcast_hit;
      match_o     <= rx_valid_i && (hits.addr_hit || hits.bcast_hit);
    end
  end

  // R5
  pulse_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o || addr_hit_o || bcast_hit_o) |-> $past(rx_valid_i));
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !(match_o || addr_hit_o || bcast_hit_o));
  // R4
  match_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o == (addr_hit_o || bcast_hit_o));
  // R1
  reset_all_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && node_q == '0 && mask_q == '0) |=> (addr_hit_o && bcast_hit_o));
endmodule

// File: tb/tb_saf_addr_filter.sv
module tb_saf_addr_filter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic         reg_sel = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic         match, addr_hit, bcast_hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m_node = '0;
  logic [W-1:0] m_mask = '0;

  always #2 clk = ~clk;

  saf_addr_filter #(.ADDR_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .match_o(match), .addr_hit_o(addr_hit), .bcast_hit_o(bcast_hit)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {match,addr,bcast} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [W-1:0] b);
    logic a, c;
    logic [W-1:0] bp;
    a  = ((b ^ m_node) & m_mask) == '0;
    bp = m_node | m_mask;
    c  = (b & bp) == bp;
    return {a | c, a, c};
  endfunction

  task automatic wr_reg(input logic sel, input logic [W-1:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel) m_mask = v; else m_node = v;
  endtask

  // one flagged byte; sample pulse then its end
  task automatic send(input string req, input logic [W-1:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    check(req, {match, addr_hit, bcast_hit}, model(b));
    @(negedge clk);
    check({req, "/R5 width"}, {match, addr_hit, bcast_hit}, 3'b000);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) send(req, W'(v));
  endtask

  task automatic t_reset;
    check("R1 idle after reset", {match, addr_hit, bcast_hit}, 3'b000);
    sweep("R1 defaults");
  endtask

  task automatic t_partial;
    wr_reg(1'b0, 8'h12);
    wr_reg(1'b1, 8'hF0);
    send("R2 addr", 8'h1A);
    send("R3 bcast", 8'hF3);
    send("R2/R3 miss", 8'h22);
    check("R2 direct", model(8'h1A), 3'b110);
    sweep("R2/R3 partial mask");
  endtask

  task automatic t_full;
    wr_reg(1'b0, 8'h05);
    wr_reg(1'b1, 8'hFF);
    send("R3 bcast FF", 8'hFF);
    send("R2 exact", 8'h05);
    send("R4 none", 8'h06);
    sweep("R2/R3/R4 full mask");
  endtask

  task automatic t_idle;
    @(negedge clk);
    rx_valid = 1'b0; rx_data = 8'h05;
    @(negedge clk);
    check("R6 strobe low", {match, addr_hit, bcast_hit}, 3'b000);
    rx_data = 8'hFF;
    @(negedge clk);
    check("R6 strobe low FF", {match, addr_hit, bcast_hit}, 3'b000);
  endtask

  task automatic t_same_cycle;
    // node=05 mask=FF; write node=40 together with byte 40 -> old regs: miss
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40;
    rx_valid = 1'b1; rx_data = 8'h40;
    @(negedge clk);
    reg_wr = 1'b0; rx_valid = 1'b0;
    check("R7 old value used", {match, addr_hit, bcast_hit}, 3'b000);
    m_node = 8'h40;
    send("R7 new value", 8'h40);
  endtask

  task automatic t_b2b;
    // node=40 mask=FF
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h40;
    @(negedge clk);
    rx_data = 8'h41;
    check("R8 first", {match, addr_hit, bcast_hit}, 3'b110);
    @(negedge clk);
    rx_data = 8'hFF;
    check("R8 second", {match, addr_hit, bcast_hit}, 3'b000);
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8 third", {match, addr_hit, bcast_hit}, 3'b101);
    @(negedge clk);
    check("R8 end", {match, addr_hit, bcast_hit}, 3'b000);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_full();
    t_idle();
    t_same_cycle();
    t_b2b();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule